// File: doc/BRIEF.md
# Triggered Two-Channel Sample Capture Buffer

This block keeps a record of pairs of channel samples in on-chip memory. After a start command it stores one pair each time the selected event occurs. The event is either a rate tick generated elsewhere or an external trigger strobe. A delayed start arms the block first. Storage then begins after a fixed number of clock cycles, chosen by a parameter; at 50 MHz, half a second is 25,000,000 cycles.

When the memory fills, one-shot mode stops storing. Loop mode keeps storing and replaces the oldest pair each time. Commands can pause storage, resume it, and clear the buffer.

The stored count is always visible. A read request gives a start index and a length. Index 0 is the oldest stored pair, and the last valid index is the stored count minus one. An accepted request streams the pairs out, one per clock. A request that reaches past the stored data raises an error pulse and returns nothing.

Top module: `sample_capture`

## Requirements
- R1: Either `rst_n` low or a `cmd_reset` strobe clears the stored count to 0 and returns the block to the stopped state, whatever its current state. A `cmd_reset` in the same cycle as a capture event wins, so nothing is stored.
- R2: With `trig_mode`=0 and storage running, each cycle with `rate_tick` high stores `{samp_a, samp_b}`, and `stored_count` rises by one on the next edge. `ext_trig` has no effect in this mode.
- R3: With `trig_mode`=1, storage happens on cycles with `ext_trig` high, and `rate_tick` has no effect. Each stored pair raises `trig_pulse` for exactly one cycle, visible after the same edge that updates the count.
- R4: With `loop_mode`=0, storage stops once `stored_count` reaches DEPTH. Later events leave both the count and the contents unchanged.
- R5: With `loop_mode`=1, an event on a full buffer overwrites the oldest pair. The count stays at DEPTH, and index 0 becomes the oldest pair still held.
- R6: A `rd_req` with `rd_idx`+`rd_len` ≤ `stored_count` streams `rd_len` pairs with `rd_valid` high, in index order from `rd_idx`. The first pair appears after the second edge following the request.
- R7: A `rd_req` with `rd_idx`+`rd_len` > `stored_count` raises `rd_err` for one cycle after the request edge, and `rd_valid` stays low. A request that ends exactly at the count is accepted.
- R8: `cmd_pause` while running stops storage, and an event in the same cycle is not stored. A pause while stopped, paused or armed for a delayed start has no effect.
- R9: `cmd_start` from the paused state resumes storage and keeps the pairs already stored.
- R10: After `cmd_delayed_start`, the first event that can be stored is the one on the (DELAY+1)-th edge after the command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_a | input | DW | Channel A sample |
| samp_b | input | DW | Channel B sample |
| rate_tick | input | 1 | Internal sample-rate strobe |
| ext_trig | input | 1 | External trigger strobe |
| trig_mode | input | 1 | 0: store on rate_tick, 1: store on ext_trig |
| loop_mode | input | 1 | 0: stop when full, 1: overwrite oldest |
| cmd_start | input | 1 | Start or resume storage |
| cmd_delayed_start | input | 1 | Start storage after DELAY cycles |
| cmd_pause | input | 1 | Pause storage |
| cmd_reset | input | 1 | Clear buffer and stop |
| stored_count | output | CW | Number of pairs held |
| rd_req | input | 1 | Read request strobe |
| rd_idx | input | CW | First index to read, 0 = oldest |
| rd_len | input | CW | Number of pairs to read |
| rd_valid | output | 1 | Read data valid |
| rd_a | output | DW | Channel A read data |
| rd_b | output | DW | Channel B read data |
| rd_err | output | 1 | Out-of-range read pulse |
| trig_pulse | output | 1 | One-cycle pulse per trigger-stored pair |

## Verification
Two pairs of controls can collide in one cycle, and each collision has a defined winner. A clear command can arrive together with a capture event, and a pause command can arrive together with one. The bench raises `rate_tick` in the same cycle as `cmd_reset`, and in another cycle together with `cmd_pause`. In the clear case it checks that the count is zero after that edge. In the pause case it checks that the count is unchanged, and a later full readout confirms that the colliding sample is absent from memory.

// File: rtl/sample_capture.sv
module sample_capture #(
  parameter int DW    = 16,
  parameter int DEPTH = 255,
  parameter int DELAY = 25_000_000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                samp_a,
  input  logic [DW-1:0]                samp_b,
  input  logic                         rate_tick,
  input  logic                         ext_trig,
  input  logic                         trig_mode,
  input  logic                         loop_mode,
  input  logic                         cmd_start,
  input  logic                         cmd_delayed_start,
  input  logic                         cmd_pause,
  input  logic                         cmd_reset,
  output logic [$clog2(DEPTH+1)-1:0]   stored_count,
  input  logic                         rd_req,
  input  logic [$clog2(DEPTH+1)-1:0]   rd_idx,
  input  logic [$clog2(DEPTH+1)-1:0]   rd_len,
  output logic                         rd_valid,
  output logic [DW-1:0]                rd_a,
  output logic [DW-1:0]                rd_b,
  output logic                         rd_err,
  output logic                         trig_pulse
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(DELAY+1);
  localparam int MW = 1 << CW;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN, S_PAUSED} st_t;

  st_t           state;
  logic [CW-1:0] wptr, rptr, rleft;
  logic [TW-1:0] dcnt;
  logic          rbusy;
  logic [DW-1:0] mem_a [MW];
  logic [DW-1:0] mem_b [MW];

  wire           full      = stored_count == CW'(DEPTH);
  wire           event_hit = trig_mode ? ext_trig : rate_tick;
  wire           store     = (state == S_RUN) && event_hit && !cmd_pause && !cmd_reset
                             && (loop_mode || !full);
  wire [CW:0]    req_end   = {1'b0, rd_idx} + {1'b0, rd_len};
  wire           req_bad   = req_end > {1'b0, stored_count};
  wire [CW-1:0]  oldest    = full ? wptr : '0;
  wire [CW:0]    phys_sum  = {1'b0, oldest} + {1'b0, rptr};
  wire [CW-1:0]  phys      = (phys_sum >= (CW+1)'(DEPTH)) ? CW'(phys_sum - (CW+1)'(DEPTH))
                                                          : CW'(phys_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      stored_count <= '0;
      wptr         <= '0;
      dcnt         <= '0;
      trig_pulse   <= 1'b0;
    end else if (cmd_reset) begin
      state        <= S_IDLE;
      stored_count <= '0;
      wptr         <= '0;
      dcnt         <= '0;
      trig_pulse   <= 1'b0;
    end else begin
      trig_pulse <= store && trig_mode;
      case (state)
        S_IDLE, S_PAUSED:
          if (cmd_start) state <= S_RUN;
          else if (cmd_delayed_start) begin
            state <= S_ARMED;
            dcnt  <= '0;
          end
        S_ARMED:
          if (dcnt == TW'(DELAY-1)) begin
            state <= S_RUN;
            dcnt  <= '0;
          end else dcnt <= dcnt + 1'b1;
        default:
          if (cmd_pause) state <= S_PAUSED;
      endcase
      if (store) begin
        wptr <= (wptr == CW'(DEPTH-1)) ? '0 : wptr + 1'b1;
        if (!full) stored_count <= stored_count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      mem_a[wptr] <= samp_a;
      mem_b[wptr] <= samp_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbusy    <= 1'b0;
      rptr     <= '0;
      rleft    <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_a     <= '0;
      rd_b     <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      if (cmd_reset) rbusy <= 1'b0;
      else if (rbusy) begin
        if (rleft == '0) rbusy <= 1'b0;
        else begin
          rd_valid <= 1'b1;
          rd_a     <= mem_a[phys];
          rd_b     <= mem_b[phys];
          rptr     <= rptr + 1'b1;
          rleft    <= rleft - 1'b1;
        end
      end else if (rd_req) begin
        if (req_bad) rd_err <= 1'b1;
        else begin
          rbusy <= 1'b1;
          rptr  <= rd_idx;
          rleft <= rd_len;
        end
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> stored_count == '0);
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stored_count != $past(stored_count) |->
      (stored_count == $past(stored_count) + CW'(1) || stored_count == '0));
  assert_trig_from_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(trig_mode && ext_trig));
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stored_count <= CW'(DEPTH));
  assert_err_excl_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_err && rd_valid));
  assert_pause_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAUSED && $past(state) == S_PAUSED) |-> $stable(stored_count));
endmodule

// File: tb/sample_capture_tb.sv
module sample_capture_tb;
  localparam int DW = 8, DEPTH = 8, DELAY = 20;
  localparam int CW = $clog2(DEPTH+1);
  // {rate_tick, ext_trig, expect_store} in internal-rate mode
  localparam bit [2:0] VEC [8] = '{3'b101, 3'b010, 3'b000, 3'b101,
                                   3'b111, 3'b010, 3'b101, 3'b000};

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] samp_a = 0, samp_b = 0;
  logic rate_tick = 0, ext_trig = 0, trig_mode = 0, loop_mode = 0;
  logic cmd_start = 0, cmd_delayed_start = 0, cmd_pause = 0, cmd_reset = 0;
  logic rd_req = 0;
  logic [CW-1:0] rd_idx = 0, rd_len = 0, stored_count;
  logic rd_valid, rd_err, trig_pulse;
  logic [DW-1:0] rd_a, rd_b;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [DW-1:0] sv = 8'h10;
  logic [DW-1:0] qa[$], qb[$];

  always #10 clk = ~clk;

  sample_capture #(.DW(DW), .DEPTH(DEPTH), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b),
    .rate_tick(rate_tick), .ext_trig(ext_trig), .trig_mode(trig_mode),
    .loop_mode(loop_mode), .cmd_start(cmd_start),
    .cmd_delayed_start(cmd_delayed_start), .cmd_pause(cmd_pause),
    .cmd_reset(cmd_reset), .stored_count(stored_count), .rd_req(rd_req),
    .rd_idx(rd_idx), .rd_len(rd_len), .rd_valid(rd_valid), .rd_a(rd_a),
    .rd_b(rd_b), .rd_err(rd_err), .trig_pulse(trig_pulse));

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_eq(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic start_cmd();
    cmd_start = 1; cyc(); cmd_start = 0;
  endtask

  task automatic step(bit tk, bit tr, bit pz, bit rs, bit exp_st, string req);
    samp_a = sv; samp_b = sv ^ 8'hA5;
    rate_tick = tk; ext_trig = tr; cmd_pause = pz; cmd_reset = rs;
    cyc();
    if (rs) begin qa.delete(); qb.delete(); end
    else if (exp_st) begin
      if (qa.size() == DEPTH) begin void'(qa.pop_front()); void'(qb.pop_front()); end
      qa.push_back(samp_a); qb.push_back(samp_b);
    end
    rate_tick = 0; ext_trig = 0; cmd_pause = 0; cmd_reset = 0;
    sv = sv + 1'b1;
    check_eq(req, "count", int'(stored_count), qa.size());
    check_eq(req, "trig_pulse", int'(trig_pulse), int'(exp_st && trig_mode && !rs));
  endtask

  task automatic do_read(int idx, int len, bit exp_err, string req);
    int got = 0, errs = 0;
    rd_idx = CW'(idx); rd_len = CW'(len); rd_req = 1;
    cyc();
    rd_req = 0;
    for (int c = 0; c < len + 4; c++) begin
      if (rd_err) errs++;
      if (rd_valid) begin
        if (!exp_err && got < len) begin
          check_eq(req, "rd_a", int'(rd_a), int'(qa[idx+got]));
          check_eq(req, "rd_b", int'(rd_b), int'(qb[idx+got]));
        end
        got++;
      end
      cyc();
    end
    check_eq(req, "err pulses", errs, int'(exp_err));
    check_eq(req, "words", got, exp_err ? 0 : len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1", "count", int'(stored_count), 0);
    check_eq("R1", "rd_valid", int'(rd_valid), 0);
    check_eq("R1", "rd_err", int'(rd_err), 0);
    check_eq("R1", "trig_pulse", int'(trig_pulse), 0);

    // R2 table walk, internal rate mode
    start_cmd();
    for (int i = 0; i < 8; i++) step(VEC[i][2], VEC[i][1], 0, 0, VEC[i][0], "R2");

    // R6 readout, R7 range checks
    do_read(0, qa.size(), 0, "R6");
    do_read(1, 2, 0, "R6");
    do_read(qa.size() - 1, 2, 1, "R7");
    do_read(0, qa.size() + 1, 1, "R7");
    do_read(2, qa.size() - 2, 0, "R7");

    // R8 pause with colliding tick, ticks while paused, pause when paused
    step(1, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");

    // R9 resume, then R4 fill and stop
    start_cmd();
    while (qa.size() < DEPTH) step(1, 0, 0, 0, 1, "R9");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    do_read(0, DEPTH, 0, "R9");

    // R1 clear colliding with a tick, then stopped
    step(1, 0, 0, 1, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");

    // R5 loop overwrite
    loop_mode = 1;
    start_cmd();
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 0, 1, "R5");
    do_read(0, DEPTH, 0, "R5");
    do_read(5, 3, 0, "R5");

    // R3 external trigger mode
    step(0, 0, 0, 1, 0, "R1");
    loop_mode = 0; trig_mode = 1;
    start_cmd();
    step(1, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 1, "R3");
    do_read(0, 2, 0, "R3");

    // R10 delayed start, pause during arming ignored (R8)
    step(0, 0, 0, 1, 0, "R1");
    trig_mode = 0;
    rate_tick = 1; cmd_delayed_start = 1;
    cyc();
    cmd_delayed_start = 0;
    for (int k = 1; k <= DELAY; k++) begin
      cmd_pause = (k == 5);
      cyc();
    end
    cmd_pause = 0;
    check_eq("R10", "count at delay end", int'(stored_count), 0);
    repeat (3) cyc();
    rate_tick = 0;
    check_eq("R10", "count after delay", int'(stored_count), 3);
    check_eq("R8", "armed pause ignored", int'(stored_count != 0), 1);

    report();
  end
endmodule